// File: doc/BRIEF.md
# Configurable Microcontroller Bus Front-End

This block sits between the external bus of a 16-bit microcontroller and an internal register or memory port. A static mode pin chooses between multiplexed addressing, where address and data share one set of lines and an address strobe marks the address phase, and non-multiplexed addressing, where the address arrives on its own lines and data uses a separate data port. Extra high-order address inputs widen the internal address beyond 16 bits.

A second static pin chooses how the three generic control pins are read. Style 0 uses separate active-low write and read strobes plus an active-low byte-high enable. Style 1 uses a read/write level qualified by an active-low data strobe, with a size pin picking byte or word transfers. Style 2 uses separate low-byte and high-byte write strobes and a shared read strobe. Style 3 disables the port. All bus inputs are brought into the internal clock domain through a two-stage pipeline, so controls, address and data stay aligned. The internal side sees a latched address, write data, two byte enables, a single-cycle write pulse and a read-enable level. The bus cannot stall, so these are plain control pins with no back-pressure. The output enables for the bus data lines are derived directly from the pins so that the bus is released as soon as the read strobe ends.

Top module: `mcu_bus_front`

## Requirements
- R1: In multiplexed mode (`mux_mode`=1) the internal address takes `{addr_ext, ad_in}` while the aligned address strobe is high and then holds that value until the strobe is next asserted.
- R2: In non-multiplexed mode the internal address follows `{addr_ext, ad_in}` with no strobe needed, and `ale` has no effect.
- R3: `int_wr` is high for exactly one clock, after the qualified write strobe is released; while it is high `int_addr`, `int_wdata` (from `ad_in` in multiplexed mode, `nm_data_in` otherwise) and `int_be` carry that access's values. No pulse occurs while the strobe is still held.
- R4: Style 0 (`bus_ctl[0]`=write strobe, `bus_ctl[1]`=read strobe, `bus_ctl[2]`=byte-high enable, all active low): with A0=0 and enable low the byte enables are 2'b11; A0=0 and enable high gives 2'b01; A0=1 and enable low gives 2'b10.
- R5: Style 1 (`bus_ctl[0]`=1 read / 0 write, `bus_ctl[1]`=data strobe active low, `bus_ctl[2]`=1 byte transfer): a word with A0=0 gives 2'b11, a byte with A0=0 gives 2'b01, a byte with A0=1 gives 2'b10, and a word with A0=1 is ignored.
- R6: Style 2 (`bus_ctl[0]`=low write strobe, `bus_ctl[2]`=high write strobe, `bus_ctl[1]`=read strobe, all active low): each write strobe enables its own lane, both together give 2'b11, and a read enables both lanes.
- R7: `ad_oe` is high only in multiplexed mode and `nm_data_oe` only in non-multiplexed mode, each only while `hit` is high and a valid read strobe is present on the pins; the driven value is `int_rdata`. Both are never high together.
- R8: During reset both output enables are low, `int_addr` is zero and `int_wr` and `int_rd` are low.
- R9: `int_rd` is high while an aligned valid read is in progress and `int_be` then shows its lanes; style 3 produces no read, write or drive.
- R10: An access with no byte lane selected (style 0 with A0=1 and byte-high enable high) produces no write pulse, no read enable and no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_mode | input | 1 | 1 = multiplexed address/data, 0 = separate lines |
| bus_style | input | 2 | Control style select (0..3) |
| ale | input | 1 | Address strobe, active high |
| bus_ctl | input | 3 | Generic control pins, meaning set by style |
| ad_in | input | 16 | Shared address/data lines (address only when not multiplexed) |
| ad_out | output | 16 | Read data for the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| addr_ext | input | 4 | High-order address inputs |
| nm_data_in | input | 16 | Separate data port input |
| nm_data_out | output | 16 | Read data for the separate data port |
| nm_data_oe | output | 1 | Drive enable for the separate data port |
| hit | input | 1 | Address decoder says the access targets this port |
| int_rdata | input | 16 | Internal read data |
| int_addr | output | 20 | Latched internal address |
| int_wdata | output | 16 | Internal write data |
| int_be | output | 2 | Byte enables, bit 0 = low byte |
| int_wr | output | 1 | One-clock internal write pulse |
| int_rd | output | 1 | Internal read enable |

## Verification
The address capture and the write pulse can fall into the same clock: a multiplexed master may release its write strobe at the very moment it raises the address strobe for the next access. The bench provokes this by changing the write strobe, the address strobe and the shared lines on one edge, and judges that the pulse carries the old address and old data while the internal address moves to the new value only afterwards.

// File: rtl/mbf_pkg.sv
package mbf_pkg;

  localparam int unsigned BUS_W = 16;
  localparam int unsigned LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    STY_STROBES = 2'd0,
    STY_LEVEL   = 2'd1,
    STY_SPLIT   = 2'd2,
    STY_OFF     = 2'd3
  } bus_style_e;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [LANES-1:0] be;
  } bus_cmd_t;

  function automatic bus_cmd_t decode_cmd(bus_style_e st, logic [2:0] c, logic a0);
    bus_cmd_t r;
    r = '0;
    unique case (st)
      STY_STROBES: begin
        r.be = {~c[2], ~a0};
        r.rd = ~c[1];
        r.wr = ~c[0];
      end
      STY_LEVEL: begin
        if (c[2]) r.be = a0 ? 2'b10 : 2'b01;
        else      r.be = a0 ? 2'b00 : 2'b11;
        r.rd = ~c[1] & c[0];
        r.wr = ~c[1] & ~c[0];
      end
      STY_SPLIT: begin
        r.wr = ~c[0] | ~c[2];
        r.rd = ~c[1] & ~r.wr;
        r.be = r.wr ? {~c[2], ~c[0]} : 2'b11;
      end
      default: r = '0;
    endcase
    if (r.be == '0) begin
      r.rd = 1'b0;
      r.wr = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/mbf_sync.sv
module mbf_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/mbf_decode.sv
module mbf_decode
  import mbf_pkg::*;
(
  input  logic [1:0]       style,
  input  logic [2:0]       ctl,
  input  logic             a0,
  output logic             rd,
  output logic             wr,
  output logic [LANES-1:0] be
);
  bus_cmd_t cmd;

  always_comb begin
    cmd = decode_cmd(bus_style_e'(style), ctl, a0);
    rd  = cmd.rd;
    wr  = cmd.wr;
    be  = cmd.be;
  end
endmodule

// File: rtl/mbf_addr_latch.sv
module mbf_addr_latch #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode,
  input  logic              ale_s,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    addr_q <= '0;
    else if (!mux_mode || ale_s)   addr_q <= addr_in;
  end

  // R1: without a strobe the multiplexed address must not move
  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_mode && !ale_s && $past(mux_mode)) |=> $stable(addr_q))
    else $error("address moved without strobe");
endmodule

// File: rtl/mbf_write_ctl.sv
module mbf_write_ctl #(
  parameter int unsigned DW    = 16,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_act,
  input  logic [LANES-1:0] be_in,
  input  logic [DW-1:0]    data_in,
  output logic             wr_pulse,
  output logic [LANES-1:0] be_hold,
  output logic [DW-1:0]    wdata
);
  logic wr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      be_hold <= '0;
      wdata   <= '0;
    end else begin
      wr_prev <= wr_act;
      if (wr_act) begin
        wdata   <= data_in;
        be_hold <= wr_prev ? (be_hold | be_in) : be_in;
      end
    end
  end

  assign wr_pulse = wr_prev & ~wr_act & (be_hold != '0);

  // R3: the write pulse never lasts longer than one clock
  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse)
    else $error("write pulse longer than one clock");

  // R3: no pulse while the qualified strobe is still active
  assert_wr_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> !wr_pulse)
    else $error("write pulse during strobe");
endmodule

// File: rtl/mcu_bus_front.sv
module mcu_bus_front
  import mbf_pkg::*;
#(
  parameter int unsigned EXT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mux_mode,
  input  logic [1:0]              bus_style,
  input  logic                    ale,
  input  logic [2:0]              bus_ctl,
  input  logic [BUS_W-1:0]        ad_in,
  output logic [BUS_W-1:0]        ad_out,
  output logic                    ad_oe,
  input  logic [EXT_W-1:0]        addr_ext,
  input  logic [BUS_W-1:0]        nm_data_in,
  output logic [BUS_W-1:0]        nm_data_out,
  output logic                    nm_data_oe,
  input  logic                    hit,
  input  logic [BUS_W-1:0]        int_rdata,
  output logic [BUS_W+EXT_W-1:0]  int_addr,
  output logic [BUS_W-1:0]        int_wdata,
  output logic [LANES-1:0]        int_be,
  output logic                    int_wr,
  output logic                    int_rd
);
  localparam int unsigned ADDR_W = BUS_W + EXT_W;
  localparam int unsigned CTL_W  = 4;
  localparam int unsigned DAT_W  = ADDR_W + BUS_W;

  // controls: {ale, ctl[2:0]}, strobes idle high, address strobe idle low
  logic [CTL_W-1:0] ctl_s;
  logic [DAT_W-1:0] dat_s;

  mbf_sync #(.W(CTL_W), .RST_VAL(4'b0111)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({ale, bus_ctl}), .q(ctl_s)
  );

  // address and data travel through the same depth as the controls
  mbf_sync #(.W(DAT_W), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n),
    .d({addr_ext, ad_in, mux_mode ? ad_in : nm_data_in}),
    .q(dat_s)
  );

  logic              ale_s;
  logic [ADDR_W-1:0] addr_s;
  logic [BUS_W-1:0]  wsrc_s;
  assign ale_s  = ctl_s[3];
  assign addr_s = dat_s[DAT_W-1:BUS_W];
  assign wsrc_s = dat_s[BUS_W-1:0];

  mbf_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .ale_s(ale_s),
    .addr_in(addr_s), .addr_q(int_addr)
  );

  // aligned decode drives the internal side
  logic             a0_s, rd_s, wr_s;
  logic [LANES-1:0] be_s;
  assign a0_s = mux_mode ? int_addr[0] : addr_s[0];

  mbf_decode u_dec_sync (
    .style(bus_style), .ctl(ctl_s[2:0]), .a0(a0_s),
    .rd(rd_s), .wr(wr_s), .be(be_s)
  );

  // pin-level decode drives only the bus output enables
  logic             a0_p, rd_p, wr_p;
  logic [LANES-1:0] be_p;
  assign a0_p = mux_mode ? int_addr[0] : ad_in[0];

  mbf_decode u_dec_pin (
    .style(bus_style), .ctl(bus_ctl), .a0(a0_p),
    .rd(rd_p), .wr(wr_p), .be(be_p)
  );

  logic [LANES-1:0] be_wr;
  mbf_write_ctl #(.DW(BUS_W), .LANES(LANES)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_s), .be_in(be_s), .data_in(wsrc_s),
    .wr_pulse(int_wr), .be_hold(be_wr), .wdata(int_wdata)
  );

  assign int_rd = rd_s;
  assign int_be = rd_s ? be_s : be_wr;

  logic drive;
  assign drive       = rst_n & hit & rd_p & ~wr_p;
  assign ad_oe       = drive & mux_mode;
  assign nm_data_oe  = drive & ~mux_mode;
  assign ad_out      = int_rdata;
  assign nm_data_out = int_rdata;

  // R7: a driven bus always has a decoder hit behind it
  assert_oe_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe || nm_data_oe) |-> hit)
    else $error("bus driven without hit");

  // R7: the two data ports are never driven together
  assert_oe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ad_oe && nm_data_oe))
    else $error("both data ports driven");

  // R9: an internal read always names at least one lane
  assert_rd_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd |-> (int_be != '0))
    else $error("read with no lanes");

  // R8: nothing drives the bus while reset is held
  always_comb begin
    if (rst_n == 1'b0) begin
      assert_oe_reset_R8: assert (!ad_oe && !nm_data_oe)
        else $error("bus driven during reset");
    end
  end
endmodule

// File: tb/tb_mcu_bus_front.sv
module tb_mcu_bus_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mux_mode = 1'b1;
  logic [1:0]  bus_style = 2'd0;
  logic        ale = 1'b0;
  logic [2:0]  bus_ctl = 3'b111;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  addr_ext = '0;
  logic [15:0] nm_data_in = '0;
  logic [15:0] nm_data_out;
  logic        nm_data_oe;
  logic        hit = 1'b0;
  logic [15:0] int_rdata = 16'hA5C3;
  logic [19:0] int_addr;
  logic [15:0] int_wdata;
  logic [1:0]  int_be;
  logic        int_wr;
  logic        int_rd;

  int errors = 0;
  int checks = 0;
  int wr_cnt = 0;
  logic [19:0] cap_addr = '0;
  logic [15:0] cap_data = '0;
  logic [1:0]  cap_be = '0;
  bit done = 0;

  always #5 clk = ~clk;

  mcu_bus_front dut (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .bus_style(bus_style),
    .ale(ale), .bus_ctl(bus_ctl), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr_ext(addr_ext), .nm_data_in(nm_data_in), .nm_data_out(nm_data_out),
    .nm_data_oe(nm_data_oe), .hit(hit), .int_rdata(int_rdata),
    .int_addr(int_addr), .int_wdata(int_wdata), .int_be(int_be),
    .int_wr(int_wr), .int_rd(int_rd)
  );

  always @(negedge clk) begin
    if (rst_n && int_wr) begin
      wr_cnt   <= wr_cnt + 1;
      cap_addr <= int_addr;
      cap_data <= int_wdata;
      cap_be   <= int_be;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write helper: assert pattern, hold, release, let pulse settle
  task automatic do_write(input logic [2:0] on, input logic [2:0] off);
    bus_ctl = on;
    cyc(5);
    bus_ctl = off;
    cyc(6);
  endtask

  task automatic t_reset;
    cyc(1);
    chk("R8 ad_oe", ad_oe, 0);
    chk("R8 nm_data_oe", nm_data_oe, 0);
    chk("R8 int_addr", int_addr, 0);
    chk("R8 int_wr", int_wr, 0);
    chk("R8 int_rd", int_rd, 0);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic t_mux_write;
    int base;
    mux_mode = 1; bus_style = 0;
    ale = 1; ad_in = 16'h1234; addr_ext = 4'h5;
    cyc(4);
    ale = 0; ad_in = 16'hBEEF;
    base = wr_cnt;
    bus_ctl = 3'b010;
    cyc(5);
    chk("R3 no pulse while held", wr_cnt - base, 0);
    bus_ctl = 3'b111;
    cyc(6);
    chk("R3 one pulse", wr_cnt - base, 1);
    chk("R1 pulse addr", cap_addr, 20'h51234);
    chk("R3 pulse data mux", cap_data, 16'hBEEF);
    chk("R4 word lanes", cap_be, 2'b11);
    chk("R1 addr held", int_addr, 20'h51234);
  endtask

  task automatic t_mux_read;
    ale = 1; ad_in = 16'h0002; addr_ext = 0;
    cyc(4);
    ale = 0; ad_in = 16'hFFFF; hit = 1;
    bus_ctl = 3'b101;
    #1;
    chk("R7 ad_oe on", ad_oe, 1);
    chk("R7 ad_out", ad_out, 16'hA5C3);
    chk("R7 nm off in mux", nm_data_oe, 0);
    cyc(4);
    chk("R9 int_rd", int_rd, 1);
    chk("R4 low lane", int_be, 2'b01);
    hit = 0; #1;
    chk("R7 no hit no drive", ad_oe, 0);
    bus_ctl = 3'b111; #1;
    chk("R7 release", ad_oe, 0);
    cyc(4);
    chk("R9 int_rd off", int_rd, 0);
  endtask

  task automatic t_nonmux;
    int base;
    mux_mode = 0; bus_style = 0;
    ad_in = 16'h0011; addr_ext = 4'h2; nm_data_in = 16'hCAFE;
    ale = 1;
    cyc(4);
    chk("R2 addr follows", int_addr, 20'h20011);
    ale = 0; ad_in = 16'h0031;
    cyc(4);
    chk("R2 no strobe needed", int_addr, 20'h20031);
    ad_in = 16'h0011;
    cyc(4);
    base = wr_cnt;
    do_write(3'b010, 3'b111);
    chk("R3 one pulse nm", wr_cnt - base, 1);
    chk("R4 high lane", cap_be, 2'b10);
    chk("R3 pulse data nm", cap_data, 16'hCAFE);
    chk("R2 pulse addr", cap_addr, 20'h20011);
    hit = 1; bus_ctl = 3'b001; #1;
    chk("R7 nm_data_oe", nm_data_oe, 1);
    chk("R7 nm_data_out", nm_data_out, 16'hA5C3);
    chk("R7 ad_oe off nm", ad_oe, 0);
    bus_ctl = 3'b111; hit = 0;
    cyc(4);
  endtask

  task automatic t_invalid;
    int base;
    ad_in = 16'h0013;
    cyc(4);
    base = wr_cnt;
    do_write(3'b110, 3'b111);
    chk("R10 no pulse", wr_cnt - base, 0);
    hit = 1; bus_ctl = 3'b101; #1;
    chk("R10 no drive", nm_data_oe, 0);
    cyc(4);
    chk("R10 no int_rd", int_rd, 0);
    bus_ctl = 3'b111; hit = 0;
    cyc(4);
  endtask

  task automatic t_level;
    int base;
    bus_style = 1; ad_in = 16'h0100; nm_data_in = 16'h1111;
    cyc(4);
    base = wr_cnt;
    do_write(3'b100, 3'b111);
    chk("R5 byte even pulse", wr_cnt - base, 1);
    chk("R5 byte even lane", cap_be, 2'b01);
    hit = 1; bus_ctl = 3'b001; #1;
    chk("R7 level read drive", nm_data_oe, 1);
    cyc(4);
    chk("R5 word read rd", int_rd, 1);
    chk("R5 word read lanes", int_be, 2'b11);
    bus_ctl = 3'b111; hit = 0;
    ad_in = 16'h0101;
    cyc(4);
    base = wr_cnt;
    do_write(3'b000, 3'b111);
    chk("R5 odd word ignored", wr_cnt - base, 0);
    base = wr_cnt;
    do_write(3'b100, 3'b111);
    chk("R5 byte odd pulse", wr_cnt - base, 1);
    chk("R5 byte odd lane", cap_be, 2'b10);
  endtask

  task automatic t_split;
    bus_style = 2; ad_in = 16'h0200; nm_data_in = 16'h2222;
    cyc(4);
    do_write(3'b110, 3'b111);
    chk("R6 low strobe lane", cap_be, 2'b01);
    do_write(3'b011, 3'b111);
    chk("R6 high strobe lane", cap_be, 2'b10);
    do_write(3'b010, 3'b111);
    chk("R6 both strobes", cap_be, 2'b11);
    chk("R6 data", cap_data, 16'h2222);
    bus_ctl = 3'b101;
    cyc(4);
    chk("R6 read rd", int_rd, 1);
    chk("R6 read lanes", int_be, 2'b11);
    bus_ctl = 3'b111;
    cyc(4);
  endtask

  task automatic t_off;
    int base;
    bus_style = 3; hit = 1; base = wr_cnt;
    bus_ctl = 3'b000; #1;
    chk("R9 style3 no drive", nm_data_oe, 0);
    cyc(5);
    chk("R9 style3 no rd", int_rd, 0);
    bus_ctl = 3'b111; hit = 0;
    cyc(6);
    chk("R9 style3 no pulse", wr_cnt - base, 0);
  endtask

  // address strobe and write release arrive on the same edge
  task automatic t_same_cycle;
    int base;
    mux_mode = 1; bus_style = 0;
    ale = 1; ad_in = 16'h0040; addr_ext = 4'h1;
    cyc(4);
    ale = 0; ad_in = 16'h7777;
    base = wr_cnt;
    bus_ctl = 3'b010;
    cyc(5);
    bus_ctl = 3'b111; ale = 1; ad_in = 16'h0088; addr_ext = 4'h2;
    cyc(6);
    ale = 0;
    chk("R3 overlap one pulse", wr_cnt - base, 1);
    chk("R1 overlap old addr", cap_addr, 20'h10040);
    chk("R3 overlap old data", cap_data, 16'h7777);
    cyc(4);
    chk("R1 overlap new addr", int_addr, 20'h20088);
  endtask

  initial begin
    t_reset();
    t_mux_write();
    t_mux_read();
    t_same_cycle();
    t_nonmux();
    t_invalid();
    t_level();
    t_split();
    t_off();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule